// File: doc/BRIEF.md
# Reference-Edge Locked Phase Counter

This block keeps a phase index inside each period of a slow, asynchronous reference clock. It counts cycles of the fast clock and returns the count to zero on every falling edge of the reference. The index therefore tells downstream logic how far it is into the current reference period. The reference may have slow, ragged transitions. It is never used as a clock. It is sampled into the fast domain through a chain of shift-register stages, and a falling edge is recognised only from two settled samples.

When no reference edge arrives, the counter does not run away. Once it reaches a fixed limit it wraps to zero on the next cycle and raises a sticky flag that reports a missed reference edge. A one-cycle pulse marks each clear caused by a real reference edge. When an edge and the limit coincide, the edge wins, and the flag stays low.

The reset input is asynchronous and active low. Inside the block, its release is retimed to the fast clock.

Top module: `phc_lock`

## Requirements
- R1: When no reference edge is detected and the count is below 56, the count grows by exactly one on each rising edge of the fast clock.
- R2: The reference input passes through three sampling stages. A falling edge is recognised when the oldest stage holds 1 and the stage behind it holds 0. If the reference is first sampled low at rising clock edge k, the count reads 0 after edge k+2, and not before. A single low level produces only one clear.
- R3: A detected falling edge forces the count to zero from any value, including the limit value 56.
- R4: With no reference edge, a count of 56 becomes 0 on the next cycle, and the count never exceeds 56.
- R5: edge_pulse_o is 1 for exactly one cycle, the cycle in which the count reads 0 because of a reference edge. It stays 0 on a wrap at the limit.
- R6: missing_edge_o goes to 1 in the cycle after a wrap at the limit without a reference edge. It then stays 1 until reset. A reference edge that clears the count while it equals 56 does not set it.
- R7: While reset is asserted, the count, edge_pulse_o and missing_edge_o are 0. All sampling stages hold 1, so a reference that is high through and after reset produces no edge pulse.
- R8: A rising edge of the reference has no effect: the count keeps incrementing and no pulse is produced.
- R9: With the reference period equal to 55 fast cycles, the count runs 0 to 54 in each period and then clears. missing_edge_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; all state is clocked on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_i | input | 1 | Raw slow reference, asynchronous to clk_i |
| count_o | output | 8 | Phase index within the current reference period |
| edge_pulse_o | output | 1 | One-cycle mark of a clear caused by a reference falling edge |
| missing_edge_o | output | 1 | Sticky flag: the count wrapped at the limit without an edge |

## Verification
The assertions assume two things about the inputs. First, reset is applied at start-up before anything is checked. Second, the reference reaches the sampling chain as a clean two-valued level, so that the only timing to reason about is the three-stage latency. The stimulus changes the reference only on falling clock edges and holds every level for many fast cycles. Reset is always released with the reference high. Edge timing is steered from the observed count, so that a clear can be placed exactly on the limit value.

// File: rtl/phc_pkg.sv
package phc_pkg;

  parameter int unsigned PHC_CNT_W      = 8;
  parameter int unsigned PHC_WRAP_LIMIT = 56;
  parameter int unsigned PHC_SYNC_STG   = 3;

  typedef enum logic [1:0] {
    PHC_ACT_INC  = 2'd0,
    PHC_ACT_EDGE = 2'd1,
    PHC_ACT_WRAP = 2'd2
  } phc_act_e;

endpackage

// File: rtl/phc_rst_sync.sv
module phc_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] rel_q;
  logic [1:0] rel_d;

  always_comb begin
    rel_d = {rel_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rel_q <= 2'b00;
    end else begin
      rel_q <= rel_d;
    end
  end

  assign rst_n_o = rel_q[1];

endmodule

// File: rtl/phc_ref_sync.sv
module phc_ref_sync #(
  parameter int unsigned STAGES = phc_pkg::PHC_SYNC_STG
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic fall_o
);

  localparam int unsigned OLD_IX = STAGES - 1;
  localparam int unsigned NEW_IX = STAGES - 2;

  logic [STAGES-1:0] smp_q;
  logic [STAGES-1:0] smp_d;

  always_comb begin
    smp_d = {smp_q[STAGES-2:0], ref_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '1;
    end else begin
      smp_q <= smp_d;
    end
  end

  assign fall_o = smp_q[OLD_IX] & ~smp_q[NEW_IX];

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R2

  AST_FALL_FROM_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(smp_q[NEW_IX]) && !$past(smp_q[NEW_IX-1])); // R2

endmodule

// File: rtl/phc_counter.sv
module phc_counter
  import phc_pkg::*;
#(
  parameter int unsigned CNT_W      = PHC_CNT_W,
  parameter int unsigned WRAP_LIMIT = PHC_WRAP_LIMIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pulse_o,
  output logic             miss_o
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(WRAP_LIMIT);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  phc_act_e         act;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             miss_q;
  logic             miss_en;

  always_comb begin
    if (fall_i) begin
      act = PHC_ACT_EDGE;
    end else if (cnt_q == LIMIT_V) begin
      act = PHC_ACT_WRAP;
    end else begin
      act = PHC_ACT_INC;
    end
  end

  always_comb begin
    cnt_d   = cnt_q + ONE_V;
    pulse_d = 1'b0;
    miss_en = 1'b0;
    case (act)
      PHC_ACT_EDGE: begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end
      PHC_ACT_WRAP: begin
        cnt_d   = '0;
        miss_en = 1'b1;
      end
      default: begin
        cnt_d = cnt_q + ONE_V;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q <= 1'b0;
    end else if (miss_en) begin
      miss_q <= 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign pulse_o = pulse_q;
  assign miss_o  = miss_q;

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && cnt_q != LIMIT_V) |=> cnt_q == $past(cnt_q) + ONE_V); // R1

  AST_EDGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> (cnt_q == '0) && pulse_q); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && cnt_q == LIMIT_V) |=> (cnt_q == '0) && miss_q && !pulse_q); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT_V); // R4

  AST_PULSE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> cnt_q == '0); // R5

  AST_MISS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q |=> miss_q); // R6

  AST_EDGE_AT_LIMIT_NO_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !miss_q) |=> !miss_q); // R6

endmodule

// File: rtl/phc_lock.sv
module phc_lock
  import phc_pkg::*;
#(
  parameter int unsigned CNT_W       = PHC_CNT_W,
  parameter int unsigned WRAP_LIMIT  = PHC_WRAP_LIMIT,
  parameter int unsigned SYNC_STAGES = PHC_SYNC_STG
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             ref_i,
  output logic [CNT_W-1:0] count_o,
  output logic             edge_pulse_o,
  output logic             missing_edge_o
);

  logic rst_n_int;
  logic ref_fall;

  phc_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_int)
  );

  phc_ref_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .ref_i  (ref_i),
    .fall_o (ref_fall)
  );

  phc_counter #(
    .CNT_W      (CNT_W),
    .WRAP_LIMIT (WRAP_LIMIT)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .fall_i  (ref_fall),
    .count_o (count_o),
    .pulse_o (edge_pulse_o),
    .miss_o  (missing_edge_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n_int |-> (count_o == '0) && !edge_pulse_o && !missing_edge_o); // R7

endmodule

// File: tb/sim_phc_lock.sv
`timescale 1ns/1ps
module sim_phc_lock;

  logic       clk;
  logic       rst_n;
  logic       refin;
  logic [7:0] count;
  logic       pulse;
  logic       miss;

  int checks;
  int errors;
  bit done;

  phc_lock u0 (
    .clk_i          (clk),
    .rst_n_i        (rst_n),
    .ref_i          (refin),
    .count_o        (count),
    .edge_pulse_o   (pulse),
    .missing_edge_o (miss)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int c);
    return (c == 56) ? 0 : c + 1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    refin = 1'b1;
    rst_n = 1'b0;
    repeat (3) step();
    chk(count == 0, "R7 count in reset", count, 0);
    chk(pulse == 0, "R7 pulse in reset", pulse, 0);
    chk(miss == 0, "R7 missing in reset", miss, 0);
    rst_n = 1'b1;
    repeat (4) step();
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        step();
        if (pulse) seen++;
      end
      chk(seen == 0, "R7 no fake edge after reset", seen, 0);
    end
  endtask

  task automatic t_increment();
    int c0 = count;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(count == nxt(c0), "R1 increment", count, nxt(c0));
      c0 = nxt(c0);
    end
  endtask

  task automatic t_edge();
    int c0 = count;
    refin = 1'b0;
    step();
    chk(count == nxt(c0) && !pulse, "R2 no clear after 1 edge", count, nxt(c0));
    step();
    chk(count == nxt(nxt(c0)) && !pulse, "R2 no clear after 2 edges", count, nxt(nxt(c0)));
    step();
    chk(count == 0, "R3 cleared by edge", count, 0);
    chk(pulse == 1, "R5 pulse on edge clear", pulse, 1);
    step();
    chk(count == 1, "R2 single clear", count, 1);
    chk(pulse == 0, "R5 pulse lasts one cycle", pulse, 0);
    for (int i = 0; i < 5; i++) step();
    chk(count == 6, "R2 held low gives no reclear", count, 6);
  endtask

  task automatic t_rise();
    int c0 = count;
    int seen = 0;
    refin = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (pulse) seen++;
      c0 = nxt(c0);
    end
    chk(count == c0, "R8 rising edge ignored", count, c0);
    chk(seen == 0, "R8 no pulse on rise", seen, 0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 100 && count != 56; i++) step();
    chk(count == 56, "R4 reaches limit", count, 56);
    chk(miss == 0, "R6 missing low before wrap", miss, 0);
    step();
    chk(count == 0, "R4 wrap to zero", count, 0);
    chk(miss == 1, "R6 missing set on wrap", miss, 1);
    chk(pulse == 0, "R5 no pulse on wrap", pulse, 0);
    step();
    chk(count == 1, "R4 counting after wrap", count, 1);
  endtask

  task automatic t_sticky();
    refin = 1'b0;
    repeat (3) step();
    chk(pulse == 1 && count == 0, "R3 edge clear after wrap", count, 0);
    repeat (5) step();
    chk(miss == 1, "R6 missing sticky across edge", miss, 1);
    refin = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_limit_edge();
    t_reset();
    for (int i = 0; i < 100 && count != 54; i++) step();
    chk(count == 54, "R3 approach limit", count, 54);
    refin = 1'b0;
    step();
    step();
    chk(count == 56, "R3 at limit with edge pending", count, 56);
    step();
    chk(count == 0, "R3 edge clear at limit", count, 0);
    chk(pulse == 1, "R5 pulse at limit clear", pulse, 1);
    chk(miss == 0, "R6 edge at limit not missing", miss, 0);
    refin = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_steady();
    int prev = -1;
    int npulse = 0;
    int bad = 0;
    t_reset();
    chk(miss == 0, "R7 missing cleared by reset", miss, 0);
    for (int i = 0; i < 55 * 7; i++) begin
      step();
      if (pulse) begin
        npulse++;
        if (npulse > 1 && prev != 54) begin
          bad++;
          chk(0, "R9 count before clear", prev, 54);
        end
      end
      prev = count;
      refin = ((i % 55) < 28) ? 1'b1 : 1'b0;
    end
    chk(npulse >= 6, "R9 pulse every period", npulse, 6);
    chk(bad == 0, "R9 steady top count", bad, 0);
    chk(miss == 0, "R9 no missing in lock", miss, 0);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    refin  = 1'b1;
    rst_n  = 1'b0;
    t_reset();
    t_increment();
    t_edge();
    t_rise();
    t_wrap();
    t_sticky();
    t_limit_edge();
    t_steady();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule